// File: doc/BRIEF.md
# GF(2^8) Serial Multiplier for Reed-Solomon Parity

This block multiplies two elements of the 256-element binary extension field that Reed-Solomon parity generators for two-dimensional barcodes use. The field is defined by the reducing polynomial x^8+x^4+x^3+x^2+1 (0x11D). The product is a carry-less multiplication: partial products are combined with XOR, never with carries. It is then reduced modulo the polynomial by conditional XOR steps, much like long division. No log, antilog or product tables are used. The block also provides field addition, which is a bitwise XOR.

A one-cycle `start` pulse loads both operands. In the default serial variant, a small state machine runs one multiplier bit per clock, most significant bit first. Each step doubles the accumulator, folds the overflow bit back with the low byte 0x1D, and adds the multiplicand when the current multiplier bit is set. The machine has three states:
- IDLE: waiting for work.
- RUN: stepping.
- DONE: result presented.

Its transitions are:
- IDLE to RUN, on `start`.
- RUN to RUN, while steps remain.
- RUN to DONE, after the W-th step.
- DONE to RUN, on `start`.
- DONE to IDLE, otherwise.

A parameter swaps in a single-cycle variant with the same ports. That variant unrolls all steps into combinational logic and registers the product one clock after `start`.

Top module: `gf256_mul`

## Requirements
- R1: `sum` always equals `op_a` XOR `op_b`, combinationally. No carry passes between bit positions.
- R2: When `done` is high, `result` equals the GF(2^8) product of the operands that were loaded, reduced modulo 0x11D.
- R3: If either loaded operand is 0x00, the product is 0x00.
- R4: If one loaded operand is 0x01, the product equals the other operand.
- R5: The product 0x80 times 0x02 is 0x1D, which is the reduction of x^8.
- R6: Serial variant timing. Suppose `start` is sampled while the block is not busy. Then `done` is high for exactly one cycle, during the cycle after the 8th clock edge that follows the edge where `start` was sampled.
- R7: Serial variant. A `start` sampled while `busy` is high is ignored: the operands, the completion time and the product of the running multiply are unchanged.
- R8: Serial variant. `busy` is high from the edge that accepts `start` until the edge where the product is written. `busy` and `done` are never high together.
- R9: Single-cycle variant (ITERATIVE=0). `done` is high in the cycle after every cycle in which `start` is sampled, so back-to-back starts are accepted. `busy` stays low.
- R10: A synchronous active-high `rst` clears `result`, `busy` and `done`, and aborts a multiply in progress.
- R11: `result` changes only at the edge that raises `done`, and is held until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load operands and begin a multiply |
| op_a | input | W | Multiplicand / first addend |
| op_b | input | W | Multiplier / second addend |
| sum | output | W | Field sum op_a XOR op_b |
| result | output | W | Registered field product |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Multiply in progress (serial variant) |

## Verification
Some properties are checked by assertions on every cycle:
- The one-cycle shape of `done`, and its spacing of exactly W busy cycles after an accepted start.
- The exclusion between `busy` and `done`.
- The holding of `result` between completions.
- The reset state.
- The zero, identity and 0x80·0x02 products, against operands captured at the accepted start.

The bench shows what the assertions cannot. It compares general products against an independent reference for all 65536 pairs on the single-cycle variant and for thousands of random pairs on the serial one. It also shows that a start arriving mid-run is really ignored, and that a reset mid-run aborts the multiply.

// File: rtl/gf256_pkg.sv
package gf256_pkg;

    localparam int GF_WIDTH = 8;
    // x^8 is folded back as x^4+x^3+x^2+1
    localparam logic [GF_WIDTH-1:0] GF_FOLD = 8'h1D;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_e;

endpackage

// File: rtl/gf_mul_step.sv
// One MSB-first shift-and-add step of a field multiply.
module gf_mul_step #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    FOLD = 8'h1D
) (
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] mcand,
    input  logic         mbit,
    output logic [W-1:0] acc_out
);

    logic [W-1:0] doubled;

    always_comb begin
        doubled = {acc_in[W-2:0], 1'b0};
        if (acc_in[W-1]) begin
            doubled = doubled ^ FOLD;
        end
        acc_out = mbit ? (doubled ^ mcand) : doubled;
    end

endmodule

// File: rtl/gf_mul_array.sv
// Fully unrolled chain of steps: single-cycle product.
module gf_mul_array #(
    parameter int           W    = 8,
    parameter logic [W-1:0] FOLD = 8'h1D
) (
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic [W-1:0] prod
);

    logic [W-1:0] stage [W+1];

    assign stage[0] = '0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_stage
            gf_mul_step #(.W(W), .FOLD(FOLD)) u_step (
                .acc_in  (stage[i]),
                .mcand   (mcand),
                .mbit    (mplier[W-1-i]),
                .acc_out (stage[i+1])
            );
        end
    endgenerate

    assign prod = stage[W];

endmodule

// File: rtl/gf_mul_ctrl.sv
// Sequencer for the serial multiply.
module gf_mul_ctrl
    import gf256_pkg::*;
#(
    parameter int STEPS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step_en,
    output logic finish,
    output logic busy,
    output logic done
);

    localparam int               CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(STEPS - 1);

    mul_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last_step;

    assign last_step = (cnt_q == LAST);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // step counter
    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt_q <= '0;
        end else if (step_en && !last_step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (last_step) state_d = ST_DONE;
            ST_DONE: state_d = start ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load    = 1'b0;
        step_en = 1'b0;
        finish  = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                step_en = 1'b1;
                busy    = 1'b1;
                finish  = last_step;
            end
            ST_DONE: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/gf256_mul.sv
module gf256_mul
    import gf256_pkg::*;
#(
    parameter int           W         = GF_WIDTH,
    parameter logic [W-1:0] FOLD      = GF_FOLD,
    parameter bit           ITERATIVE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum,
    output logic [W-1:0] result,
    output logic         done,
    output logic         busy
);

    logic [W-1:0] result_q;
    logic         done_w;
    logic         busy_w;

    // field addition: bitwise, no carries
    assign sum = op_a ^ op_b;

    generate
        if (ITERATIVE) begin : g_serial
            logic         load, step_en, finish;
            logic [W-1:0] mcand_q, mplier_q, acc_q, acc_next;

            gf_mul_ctrl #(.STEPS(W)) u_ctrl (
                .clk     (clk),
                .rst     (rst),
                .start   (start),
                .load    (load),
                .step_en (step_en),
                .finish  (finish),
                .busy    (busy_w),
                .done    (done_w)
            );

            gf_mul_step #(.W(W), .FOLD(FOLD)) u_step (
                .acc_in  (acc_q),
                .mcand   (mcand_q),
                .mbit    (mplier_q[W-1]),
                .acc_out (acc_next)
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    mcand_q  <= '0;
                    mplier_q <= '0;
                    acc_q    <= '0;
                    result_q <= '0;
                end else if (load) begin
                    mcand_q  <= op_a;
                    mplier_q <= op_b;
                    acc_q    <= '0;
                end else if (step_en) begin
                    acc_q    <= acc_next;
                    mplier_q <= {mplier_q[W-2:0], 1'b0};
                    if (finish) begin
                        result_q <= acc_next;
                    end
                end
            end
        end else begin : g_single
            logic [W-1:0] prod;
            logic         done_q;

            gf_mul_array #(.W(W), .FOLD(FOLD)) u_array (
                .mcand  (op_a),
                .mplier (op_b),
                .prod   (prod)
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    result_q <= '0;
                    done_q   <= 1'b0;
                end else begin
                    done_q <= start;
                    if (start) begin
                        result_q <= prod;
                    end
                end
            end

            assign done_w = done_q;
            assign busy_w = 1'b0;
        end
    endgenerate

    assign result = result_q;
    assign done   = done_w;
    assign busy   = busy_w;

endmodule

// File: rtl/gf256_mul_chk.sv
module gf256_mul_chk #(
    parameter int W         = 8,
    parameter bit ITERATIVE = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [W-1:0] result,
    input logic         done,
    input logic         busy
);

    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TOP = W'(1) << (W - 1);
    localparam logic [W-1:0] TWO = W'(2);

    logic [W-1:0] cap_a, cap_b;
    logic         accept;

    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_a <= '0;
            cap_b <= '0;
        end else if (accept) begin
            cap_a <= op_a;
            cap_b <= op_b;
        end
    end

    a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (result == '0 && !done && !busy));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(result));

    a_r3_zero: assert property (@(posedge clk) disable iff (rst)
        (done && (cap_a == '0 || cap_b == '0)) |-> result == '0);

    a_r4_one_b: assert property (@(posedge clk) disable iff (rst)
        (done && cap_b == ONE) |-> result == cap_a);

    a_r4_one_a: assert property (@(posedge clk) disable iff (rst)
        (done && cap_a == ONE) |-> result == cap_b);

    a_r5_fold: assert property (@(posedge clk) disable iff (rst)
        (done && cap_a == TOP && cap_b == TWO && W == 8) |-> result == 8'h1D);

    generate
        if (ITERATIVE) begin : g_serial_chk
            localparam int LEN_W = $clog2(W) + 2;
            logic [LEN_W-1:0] run_len;

            always_ff @(posedge clk) begin
                if (rst || accept) begin
                    run_len <= '0;
                end else if (busy) begin
                    run_len <= run_len + 1'b1;
                end
            end

            a_r6_pulse: assert property (@(posedge clk) disable iff (rst)
                done |=> !done);

            a_r6_latency: assert property (@(posedge clk) disable iff (rst)
                done |-> run_len == LEN_W'(W));

            a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
                busy |-> !done);

            a_r8_start_busy: assert property (@(posedge clk) disable iff (rst)
                accept |=> busy);
        end else begin : g_single_chk
            a_r9_next: assert property (@(posedge clk) disable iff (rst)
                start |=> done);

            a_r9_idle: assert property (@(posedge clk) disable iff (rst)
                !busy);
        end
    endgenerate

endmodule

bind gf256_mul gf256_mul_chk #(.W(W), .ITERATIVE(ITERATIVE)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op_a   (op_a),
    .op_b   (op_b),
    .result (result),
    .done   (done),
    .busy   (busy)
);

// File: tb/gf256_mul_bench.sv
`timescale 1ns/1ps
module gf256_mul_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    int         checks = 0;
    int         fails  = 0;

    // serial instance
    logic       s_start = 1'b0;
    logic [7:0] s_a = '0, s_b = '0;
    logic [7:0] s_sum, s_res;
    logic       s_done, s_busy;

    // single-cycle instance
    logic       f_start = 1'b0;
    logic [7:0] f_a = '0, f_b = '0;
    logic [7:0] f_sum, f_res;
    logic       f_done, f_busy;

    always #2.5 clk = ~clk;

    gf256_mul u_gf256_mul (
        .clk(clk), .rst(rst), .start(s_start), .op_a(s_a), .op_b(s_b),
        .sum(s_sum), .result(s_res), .done(s_done), .busy(s_busy)
    );

    gf256_mul #(.ITERATIVE(1'b0)) u_gf256_mul_fast (
        .clk(clk), .rst(rst), .start(f_start), .op_a(f_a), .op_b(f_b),
        .sum(f_sum), .result(f_res), .done(f_done), .busy(f_busy)
    );

    // LSB-first reference: add shifted multiplicand, reduce by 0x11D each shift
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = '0;
        logic [8:0] aa = {1'b0, a};
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ aa[7:0];
            aa = {aa[7:0], 1'b0};
            if (aa[8]) aa = aa ^ 9'h11D;
        end
        return p;
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // serial multiply with full timing check; optional mid-run start injection
    task automatic run_serial(input logic [7:0] a, input logic [7:0] b, input bit inject);
        logic [7:0] exp = ref_mul(a, b);
        @(negedge clk);
        s_a = a; s_b = b; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        check(s_busy == 1'b1, "R8 busy after start", 16'(s_busy), 16'd1);
        for (int n = 1; n <= 8; n++) begin
            if (inject && n == 2) begin
                s_a = ~a; s_b = b ^ 8'h5A; s_start = 1'b1;
            end
            @(negedge clk);
            s_start = 1'b0;
            if (n < 8) begin
                if (s_done) check(1'b0, "R6 early done", 16'(n), 16'd8);
                if (!s_busy) check(1'b0, "R8 busy dropped", 16'(n), 16'd8);
            end
        end
        check(s_done == 1'b1, "R6 done at 8th edge", 16'(s_done), 16'd1);
        check(s_busy == 1'b0, "R8 busy low at done", 16'(s_busy), 16'd0);
        check(s_res == exp, inject ? "R7 ignored start" : "R2 serial product", 16'(s_res), 16'(exp));
        @(negedge clk);
        check(s_done == 1'b0, "R6 done one cycle", 16'(s_done), 16'd0);
        check(s_res == exp, "R11 result held", 16'(s_res), 16'(exp));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] pa, pb, ea;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(s_res == 8'h00 && !s_done && !s_busy, "R10 serial reset", 16'(s_res), 16'd0);
        check(f_res == 8'h00 && !f_done && !f_busy, "R10 single reset", 16'(f_res), 16'd0);

        // R1 field addition
        for (int k = 0; k < 16; k++) begin
            s_a = 8'($urandom); s_b = 8'($urandom);
            #1;
            check(s_sum == (s_a ^ s_b), "R1 xor sum", 16'(s_sum), 16'(s_a ^ s_b));
        end

        // directed serial corners
        run_serial(8'h00, 8'hC3, 1'b0);   // R3
        check(s_res == 8'h00, "R3 zero operand", 16'(s_res), 16'd0);
        run_serial(8'h9E, 8'h00, 1'b0);   // R3
        check(s_res == 8'h00, "R3 zero multiplier", 16'(s_res), 16'd0);
        run_serial(8'h01, 8'hB7, 1'b0);   // R4
        check(s_res == 8'hB7, "R4 identity a", 16'(s_res), 16'hB7);
        run_serial(8'h6D, 8'h01, 1'b0);   // R4
        check(s_res == 8'h6D, "R4 identity b", 16'(s_res), 16'h6D);
        run_serial(8'h80, 8'h02, 1'b0);   // R5
        check(s_res == 8'h1D, "R5 x^8 fold", 16'(s_res), 16'h1D);
        run_serial(8'hFF, 8'hFF, 1'b0);
        run_serial(8'h53, 8'hCA, 1'b1);   // R7

        // R10 reset aborts a run
        @(negedge clk);
        s_a = 8'h37; s_b = 8'h91; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!s_busy && !s_done && s_res == 8'h00, "R10 abort", 16'(s_res), 16'd0);
        repeat (8) @(negedge clk);
        check(s_done == 1'b0, "R10 no late done", 16'(s_done), 16'd0);

        // random serial
        for (int k = 0; k < 3000; k++) begin
            run_serial(8'($urandom), 8'($urandom), (k % 97) == 0);
        end

        // single-cycle variant: exhaustive, back-to-back (R2, R9)
        @(negedge clk);
        f_a = 8'h00; f_b = 8'h00; f_start = 1'b1;
        for (int i = 0; i < 65536; i++) begin
            pa = f_a; pb = f_b;
            @(negedge clk);
            ea = ref_mul(pa, pb);
            if (!f_done) check(1'b0, "R9 done next cycle", 16'(f_done), 16'd1);
            if (f_res != ea) check(1'b0, "R2 single product", {pa, pb}, 16'(ea));
            else checks++;
            if (i == 65535) f_start = 1'b0;
            else begin
                f_a = 8'((i + 1) >> 8); f_b = 8'(i + 1);
            end
        end
        check(f_busy == 1'b0, "R9 busy low", 16'(f_busy), 16'd0);
        ea = f_res;
        @(negedge clk);
        check(f_done == 1'b0, "R9 no start no done", 16'(f_done), 16'd0);
        check(f_res == ea, "R11 single hold", 16'(f_res), 16'(ea));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule